// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into a framed asynchronous bit stream on a single output line. A seven-bit line-control word sets the frame: five to eight data bits, one or more stop bits, an optional parity bit with odd, even, mark or space behaviour, and a break override. The line rests high. Each frame is a low start bit, then the data bits sent least significant bit first, then the parity bit if it is enabled, then the stop time at logic 1.

Bit timing comes from an external strobe, `baud_tick`, which pulses once for every sixteenth of a bit. A written character first goes into a one-entry holding register. When the shifter is idle, the character moves into the shifter. The control word is captured at that same transfer, so a character already on the line keeps its format. Two status outputs show when the holding register is free and when the whole transmitter has drained.

The break control acts only on the output pin. While break is set the line is held low, but the shifter and both status flags keep running as usual. Software can therefore time the break length by sending characters.

Top module: `async_tx`

## Requirements
- R1: After reset, `serial_out` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: `line_ctl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that length are not sent.
- R3: A frame is one start bit at 0, then the data bits least significant first, then the stop time at 1. The line is 1 when idle. The start bit appears the cycle after the character moves into the shifter.
- R4: When `line_ctl[3]` is 1, one parity bit is sent after the last data bit and before the stop time.
- R5: With parity on and `line_ctl[5]` = 0, `line_ctl[4]` = 0 makes the count of ones in data plus parity odd, and `line_ctl[4]` = 1 makes it even.
- R6: With parity on and `line_ctl[5]` = 1, the parity bit is the inverse of `line_ctl[4]`: mark (1) when bit 4 is 0, space (0) when bit 4 is 1.
- R7: Each bit lasts 16 ticks. The stop time is 16 ticks when `line_ctl[2]` = 0. With `line_ctl[2]` = 1 it is 24 ticks for 5-bit data and 32 ticks for 6, 7 or 8-bit data.
- R8: While `line_ctl[6]` is 1, `serial_out` is 0. Frame timing and `tx_empty` go on exactly as without break.
- R9: `hold_empty` falls the cycle after a write into an empty holding register. It rises again the cycle after the character moves to the shifter. `tx_empty` is 1 only when the holding register and the shifter are both empty.
- R10: A write while `hold_empty` is 0 is ignored: the waiting character is unchanged and no extra frame is sent.
- R11: The line-control word is sampled when a character moves into the shifter. Changes made while that frame is being sent do not affect its bits or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| line_ctl | input | 7 | Frame control: [1:0] length, [2] long stop, [3] parity on, [4] even/space, [5] stick, [6] break |
| wr_en | input | 1 | Write strobe for `wr_data` into the holding register |
| wr_data | input | 8 | Character to send |
| serial_out | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
`hold_empty` falls one cycle after a write. The character moves to the shifter on the next edge if the shifter is idle, so one cycle after that `hold_empty` is 1 again and the start bit is on the line. The bench samples those flags on exactly those falling edges. A frame ends on the edge of its last tick, T, counted after the transfer. With ticks every P cycles, `tx_empty` therefore rises between (T-1)·P+1 and T·P cycles after the transfer, and the bench accepts only that window. This window is what tells 16, 24 and 32-tick stop times apart. The scoreboard monitor keys on the falling start edge. It samples each bit half a bit period into it, so the up-to-one-tick phase offset of the strobe stays well inside the bit.

// File: rtl/async_tx_pkg.sv
// Package: shared types and the parity rule for the asynchronous transmitter.
// Assumes character lengths of 5 to 8 bits selected by a two-bit code.
package async_tx_pkg;

    parameter int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Field order matches the bit positions of the line-control port.
    typedef struct packed {
        logic       brk;
        logic       stick;
        logic       even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] wlen;
    } line_cfg_t;

    // Parity bit for a character under the given control word.
    function automatic logic parity_bit(logic [DATA_W-1:0] d, line_cfg_t c);
        logic [DATA_W-1:0] mask;
        logic              ones;
        mask = {DATA_W{1'b1}} >> (2'd3 - c.wlen);
        ones = ^(d & mask);
        if (c.stick)
            return ~c.even;
        return c.even ? ones : ~ones;
    endfunction

endpackage

// File: rtl/async_tx_hold.sv
// One-entry holding register in front of the shifter.
// Takes a write only when empty; a write while full is dropped.
// Assumes 'take' is raised only while the register is full.
module async_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] data_o,
    output logic          full_o
);

    // Capture a character when empty, release it on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
        end else if (wr_en && !full_o) begin
            data_o <= wr_data;
            full_o <= 1'b1;
        end else if (take) begin
            full_o <= 1'b0;
        end
    end

endmodule

// File: rtl/async_tx_tickcnt.sv
// Counts baud ticks within one bit slot and flags the tick that closes the
// slot (count equal to limit). Held at zero while 'clr' is high.
module async_tx_tickcnt #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt;

    // The slot ends on the tick that finds the count at its limit.
    assign done = tick && !clr && (cnt == limit);

    // Advance on each tick, wrap at the end of a slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/async_tx_shift.sv
// Frame sequencer and shift register. It pulls a character from the holding
// register when idle, latches the control word with it, and steps through
// start, data, parity and stop slots, each timed in baud ticks.
// Assumes OVS is even so that half a bit is a whole number of ticks.
module async_tx_shift
    import async_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] data_i,
    input  line_cfg_t         cfg_i,
    output logic              take_o,
    output logic              line_o,
    output logic              idle_o,
    output line_cfg_t         cfg_q_o
);

    localparam int CW  = $clog2(2 * OVS);
    localparam int NBW = $clog2(DATA_W);
    localparam logic [CW-1:0] LIM_BIT  = CW'(OVS - 1);
    localparam logic [CW-1:0] LIM_HALF = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OVS - 1);

    tx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [NBW-1:0]    nbit;
    logic              par_q;
    line_cfg_t         cfg_q;
    logic [CW-1:0]     limit;
    logic              slot_done;
    logic              last_bit;

    assign idle_o   = (st == ST_IDLE);
    assign take_o   = idle_o && hold_full;
    assign cfg_q_o  = cfg_q;
    assign last_bit = (nbit == NBW'(4) + NBW'(cfg_q.wlen));

    // Slot length: one bit, or the chosen stop time.
    always_comb begin
        limit = LIM_BIT;
        if (st == ST_STOP && cfg_q.stop_long)
            limit = (cfg_q.wlen == 2'b00) ? LIM_HALF : LIM_TWO;
    end

    async_tx_tickcnt #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_o),
        .tick  (tick),
        .limit (limit),
        .done  (slot_done)
    );

    // Frame state: load on transfer, advance at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sh    <= '0;
            nbit  <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else if (take_o) begin
            st    <= ST_START;
            sh    <= data_i;
            nbit  <= '0;
            cfg_q <= cfg_i;
            par_q <= parity_bit(data_i, cfg_i);
        end else if (slot_done) begin
            unique case (st)
                ST_START: st <= ST_DATA;
                ST_DATA: begin
                    sh   <= sh >> 1;
                    nbit <= nbit + 1'b1;
                    if (last_bit)
                        st <= cfg_q.par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR:  st <= ST_STOP;
                ST_STOP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Line level for the current slot.
    always_comb begin
        unique case (st)
            ST_START: line_o = 1'b0;
            ST_DATA:  line_o = sh[0];
            ST_PAR:   line_o = par_q;
            default:  line_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/async_tx.sv
// Top of the asynchronous transmitter: holding register, frame sequencer,
// status flags and the break override on the output pin.
// Assumes baud_tick is a one-cycle pulse at sixteen times the bit rate.
module async_tx
    import async_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [6:0]        line_ctl,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              serial_out,
    output logic              hold_empty,
    output logic              tx_empty
);

    line_cfg_t         cfg_live;
    line_cfg_t         cfg_q_w;
    logic              take_w;
    logic              full_w;
    logic              idle_w;
    logic              line_w;
    logic [DATA_W-1:0] hold_data_w;

    assign cfg_live = line_cfg_t'(line_ctl);

    async_tx_hold #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_w),
        .data_o  (hold_data_w),
        .full_o  (full_w)
    );

    async_tx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .hold_full (full_w),
        .data_i    (hold_data_w),
        .cfg_i     (cfg_live),
        .take_o    (take_w),
        .line_o    (line_w),
        .idle_o    (idle_w),
        .cfg_q_o   (cfg_q_w)
    );

    // Status flags and the break override, which only touches the pin.
    always_comb begin
        hold_empty = !full_w;
        tx_empty   = !full_w && idle_w;
        serial_out = cfg_live.brk ? 1'b0 : line_w;
    end

endmodule

// File: rtl/async_tx_chk.sv
// Checker for async_tx: protocol properties over ports and internal transfer
// signals, attached to every instance of the top by the bind below.
module async_tx_chk
    import async_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        line_ctl,
    input logic              wr_en,
    input logic              serial_out,
    input logic              hold_empty,
    input logic              tx_empty,
    input logic              take,
    input logic [DATA_W-1:0] hold_data,
    input logic              sh_idle,
    input line_cfg_t         cfg_q
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctl[6]) |-> serial_out);  // R3

    AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line_ctl[6] || !serial_out));  // R3

    AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !serial_out);  // R8

    AST_TRANSFER_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> hold_empty);  // R9

    AST_WRITE_WHEN_FULL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_empty) |=> $stable(hold_data));  // R10

    AST_FORMAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_idle && $past(!sh_idle)) |-> $stable(cfg_q));  // R11

endmodule

bind async_tx async_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_ctl   (line_ctl),
    .wr_en      (wr_en),
    .serial_out (serial_out),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .take       (take_w),
    .hold_data  (hold_data_w),
    .sh_idle    (idle_w),
    .cfg_q      (cfg_q_w)
);

// File: tb/async_tx_tb.sv
// Scoreboard bench: the driver queues each expected character with its
// control word; a monitor decodes frames from the line and compares.
module async_tx_tb;

    localparam int P = 2;  // clock cycles per baud tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [6:0] line_ctl = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       serial_out;
    logic       hold_empty;
    logic       tx_empty;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit mon_busy = 1'b0;
    int ph = 0;

    logic [7:0] exp_d_q[$];
    logic [6:0] exp_c_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    async_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .line_ctl   (line_ctl),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .serial_out (serial_out),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    // Tick strobe: one cycle high every P cycles.
    always @(negedge clk) begin
        ph        <= (ph + 1) % P;
        baud_tick <= (ph == P - 1);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] mk(input logic [1:0] wl, input bit stop2,
                                      input bit pen, input bit ev,
                                      input bit stick, input bit brk);
        return {brk, stick, ev, pen, stop2, wl};
    endfunction

    function automatic int nbits(input logic [6:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [6:0] c);
        int ones = 0;
        for (int i = 0; i < nbits(c); i++) ones += int'(d[i]);
        if (c[5]) return !c[4];
        if (c[4]) return (ones % 2) == 1;
        return (ones % 2) == 0;
    endfunction

    function automatic int frame_bits(input logic [6:0] c);
        return 2 + nbits(c) + int'(c[3]);
    endfunction

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [6:0] c);
        logic [11:0] v = '0;
        int pos = 1;
        for (int i = 0; i < nbits(c); i++) begin
            v[pos] = d[i];
            pos++;
        end
        if (c[3]) begin
            v[pos] = exp_par(d, c);
            pos++;
        end
        v[pos] = 1'b1;
        return v;
    endfunction

    function automatic int total_ticks(input logic [6:0] c);
        int st = 16;
        if (c[2]) st = (c[1:0] == 2'b00) ? 24 : 32;
        return 16 * (1 + nbits(c) + int'(c[3])) + st;
    endfunction

    // Monitor: decode each frame at mid-bit and compare with the queue head.
    initial begin
        logic [11:0] got;
        logic [7:0]  d;
        logic [6:0]  c;
        string       tag;
        forever begin
            @(negedge clk);
            if (mon_en && serial_out === 1'b0) begin
                mon_busy = 1'b1;
                if (exp_d_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected frame", 1, 0);
                    while (!tx_empty) @(negedge clk);
                end else begin
                    d   = exp_d_q.pop_front();
                    c   = exp_c_q.pop_front();
                    tag = tag_q.pop_front();
                    got = '0;
                    repeat (8 * P) @(negedge clk);
                    got[0] = serial_out;
                    for (int i = 1; i < frame_bits(c); i++) begin
                        repeat (16 * P) @(negedge clk);
                        got[i] = serial_out;
                    end
                    check(got == exp_frame(d, c), tag, "frame bits",
                          int'(got), int'(exp_frame(d, c)));
                end
                mon_busy = 1'b0;
            end
        end
    end

    // Driver: write one character once the holding register is free.
    task automatic send(input logic [7:0] d, input string tag, input bit push);
        @(negedge clk);
        while (!hold_empty) @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        if (push) begin
            exp_d_q.push_back(d);
            exp_c_q.push_back(line_ctl);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty || mon_busy || exp_d_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [6:0] c);
        wait_idle();
        line_ctl = c;
    endtask

    // Counts cycles from the transfer until tx_empty; call right after send.
    task automatic measure(output int cyc, output int highs);
        cyc = 0;
        highs = 0;
        @(negedge clk);
        while (!tx_empty) begin
            if (serial_out) highs++;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic len_check(input logic [6:0] c, input logic [7:0] d, input string tag);
        int cyc, highs, t;
        set_cfg(c);
        t = total_ticks(c);
        send(d, tag, 1'b1);
        measure(cyc, highs);
        check(cyc >= (t - 1) * P + 1 && cyc <= t * P, tag, "frame length cycles", cyc, t * P);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        int cyc, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(serial_out == 1'b1, "R1", "serial_out after reset", serial_out, 1);
        check(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
        check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);

        line_ctl = mk(2'b11, 0, 0, 0, 0, 0);
        mon_en = 1'b1;

        // R9 flag timing around one write
        @(negedge clk);
        wr_data = 8'hA5;
        wr_en   = 1'b1;
        exp_d_q.push_back(8'hA5);
        exp_c_q.push_back(line_ctl);
        tag_q.push_back("R3");
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R9", "hold_empty after write", hold_empty, 0);
        check(tx_empty == 1'b0, "R9", "tx_empty while holding", tx_empty, 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R9", "hold_empty after transfer", hold_empty, 1);
        check(tx_empty == 1'b0, "R9", "tx_empty while shifting", tx_empty, 0);
        check(serial_out == 1'b0, "R3", "start bit after transfer", serial_out, 0);

        // R10 back-to-back, then a write into a full holding register
        send(8'h3C, "R9", 1'b1);
        @(negedge clk);
        wr_data = 8'hE7;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R10", "hold stays full after dropped write", hold_empty, 0);
        wait_idle();
        check(exp_d_q.size() == 0, "R10", "queue drained", exp_d_q.size(), 0);

        // R2 word lengths
        set_cfg(mk(2'b00, 0, 0, 0, 0, 0)); send(8'hF3, "R2", 1'b1);
        set_cfg(mk(2'b01, 0, 0, 0, 0, 0)); send(8'h2D, "R2", 1'b1);
        set_cfg(mk(2'b10, 0, 0, 0, 0, 0)); send(8'hD5, "R2", 1'b1);

        // R4 / R5 parity placement and sense
        set_cfg(mk(2'b11, 0, 1, 0, 0, 0)); send(8'h37, "R5", 1'b1);
        set_cfg(mk(2'b11, 0, 1, 1, 0, 0)); send(8'h37, "R5", 1'b1);
        set_cfg(mk(2'b10, 0, 1, 1, 0, 0)); send(8'h01, "R4", 1'b1);
        set_cfg(mk(2'b00, 0, 1, 0, 0, 0)); send(8'h00, "R4", 1'b1);

        // R6 stick parity
        set_cfg(mk(2'b11, 0, 1, 0, 1, 0)); send(8'h00, "R6", 1'b1);
        set_cfg(mk(2'b11, 0, 1, 1, 1, 0)); send(8'hFF, "R6", 1'b1);
        set_cfg(mk(2'b01, 0, 1, 0, 1, 0)); send(8'h3F, "R6", 1'b1);

        // R7 stop time lengths
        len_check(mk(2'b11, 0, 0, 0, 0, 0), 8'h81, "R7");
        len_check(mk(2'b00, 1, 0, 0, 0, 0), 8'h15, "R7");
        len_check(mk(2'b01, 1, 0, 0, 0, 0), 8'h2A, "R7");
        len_check(mk(2'b11, 1, 1, 1, 0, 0), 8'h5A, "R7");

        // R8 break: line low, timing unchanged
        wait_idle();
        mon_en = 1'b0;
        line_ctl = mk(2'b11, 0, 0, 0, 0, 1);
        send(8'hFF, "R8", 1'b0);
        measure(cyc, highs);
        check(highs == 0, "R8", "high cycles during break", highs, 0);
        check(cyc >= 159 * P + 1 && cyc <= 160 * P, "R8", "frame length under break", cyc, 160 * P);
        check(serial_out == 1'b0, "R8", "line low after frame in break", serial_out, 0);
        @(negedge clk);
        line_ctl = mk(2'b11, 0, 0, 0, 0, 0);
        @(negedge clk);
        check(serial_out == 1'b1, "R8", "line high after break cleared", serial_out, 1);
        mon_en = 1'b1;

        // R11 control change mid-frame
        set_cfg(mk(2'b11, 0, 0, 0, 0, 0));
        send(8'h96, "R11", 1'b1);
        fork
            begin
                repeat (40) @(negedge clk);
                line_ctl = mk(2'b00, 1, 1, 1, 0, 0);
            end
            measure(cyc, highs);
        join
        check(cyc >= 159 * P + 1 && cyc <= 160 * P, "R11", "frame length kept", cyc, 160 * P);
        wait_idle();
        check(exp_d_q.size() == 0, "R3", "all frames seen", exp_d_q.size(), 0);

        report();
        $finish;
    end

endmodule